// File: doc/BRIEF.md
# Two-Level Page Translation Unit with Translation Cache

This block turns 32-bit linear addresses into physical addresses. When the paging control input is low, the linear address is returned unchanged. When it is high, the block first looks the upper 20 bits up in a small, fully associative translation cache. A hit returns the cached frame number joined to the untouched 12-bit byte offset, and no memory read is made. On a miss, a hardware walker makes two reads over a valid/ready memory request port. The first read fetches a directory entry, chosen by bits 31:22. The second fetches a page-table entry, chosen by bits 21:12. The walker then completes the translation and fills the cache.

A table entry whose present flag is clear ends the walk with a page fault. The faulting linear address is then captured in a fault-address register that stays visible on an output. A flush input invalidates the whole cache. The block handles one translation at a time: a request is accepted only while the block is idle, and every result comes back as a single-cycle response pulse.

Top module: `pager_mmu`

## Requirements
- R1: With `pg_enable` low at acceptance, the response arrives one cycle after the accepting edge with `rsp_paddr` equal to the request address, `rsp_fault` low, and no memory read.
- R2: On a miss, the first memory read addresses the directory entry at `{dir_base, laddr[31:22], 2'b00}`.
- R3: If that entry has bit 0 set, the second read addresses `{entry[31:12], laddr[21:12], 2'b00}`. A present page entry yields `rsp_paddr = {page_entry[31:12], laddr[11:0]}`.
- R4: A directory entry with bit 0 clear ends the walk after exactly one memory read, with `rsp_fault` high.
- R5: A page entry with bit 0 clear gives `rsp_fault` high after exactly two memory reads.
- R6: On a fault, `rsp_paddr` is zero and `fault_addr` takes the full linear address in the same cycle that the response shows. `fault_addr` changes at no other time.
- R7: When paging is on, a cache hit answers one cycle after acceptance with the cached frame and the request's offset, and makes no memory read.
- R8: Every walk that succeeds fills one of 8 cache entries. Entries are replaced in round-robin order, so the ninth distinct page evicts the first.
- R9: `tlb_flush` invalidates every entry. A flush in the cycle of acceptance forces a walk. A flush in the cycle of a fill wins, and the filled page is not cached.
- R10: `req_ready` is low from acceptance until the response has been given. A memory request that is stalled keeps `mem_req_valid` high and its address stable until `mem_req_ready` is seen.
- R11: `rsp_valid` is high for exactly one cycle per accepted request.
- R12: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, `fault_addr` is zero, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_enable | input | 1 | Paging on when high, sampled at acceptance |
| dir_base | input | 20 | Frame number of the page directory |
| tlb_flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault flag for this response |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
Two things can collide with the cache state. A flush can land in the very cycle that a lookup is accepted, and a flush can land in the very edge at which a completed walk writes its fill. The bench provokes the first by raising `tlb_flush` together with `req_valid` for a page that is known to be cached. It provokes the second from the memory model, which raises the flush in the same cycle that it returns the page-table entry. In both cases the verdict comes from the port activity on the next request for that page: two memory reads must be seen where a hit would have made none, while the translated address stays correct.

// File: rtl/pager_pkg.sv
package pager_pkg;
  localparam int LA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int VPN_W = LA_W - OFF_W;
  localparam int PRESENT_BIT = 0;

  typedef enum logic [1:0] {M_IDLE, M_WALK, M_RESP} mmu_st_e;
  typedef enum logic [2:0] {W_IDLE, W_DIR_REQ, W_DIR_WAIT, W_PTE_REQ, W_PTE_WAIT} walk_st_e;
endpackage

// File: rtl/pager_rst_sync.sv
module pager_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pager_tlb.sv
module pager_tlb #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PFN_W-1:0] fill_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d, match;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               fill_do;

  // flush has priority over a fill in the same cycle
  assign fill_do = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign match[g] = valid_q[g] && (tag_q[g] == lookup_tag);

    always_ff @(posedge clk) begin
      if (fill_do && (ptr_q == PTR_W'(g))) begin
        tag_q[g] <= fill_tag;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
    end
  end
  assign hit = |match;

  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (flush) begin
      valid_d = '0;
    end else if (fill_do) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ptr_q == PTR_W'(i)) valid_d[i] = 1'b1;
      end
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end
endmodule

// File: rtl/pager_walker.sv
module pager_walker
  import pager_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] vpn,
  input  logic [VPN_W-1:0] dir_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [LA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [LA_W-1:0]  mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [VPN_W-1:0] pfn
);
  walk_st_e         st_q, st_d;
  logic [VPN_W-1:0] tbl_q;
  logic             tbl_en;
  logic             present;
  logic [OFF_W-2:0] rsvd_unused;

  assign present     = mem_rsp_data[PRESENT_BIT];
  assign pfn         = mem_rsp_data[LA_W-1:OFF_W];
  assign rsvd_unused = mem_rsp_data[OFF_W-1:1];

  always_comb begin
    st_d   = st_q;
    tbl_en = 1'b0;
    done   = 1'b0;
    fault  = 1'b0;
    unique case (st_q)
      W_IDLE:     if (start) st_d = W_DIR_REQ;
      W_DIR_REQ:  if (mem_req_ready) st_d = W_DIR_WAIT;
      W_DIR_WAIT: if (mem_rsp_valid) begin
        if (present) begin
          tbl_en = 1'b1;
          st_d   = W_PTE_REQ;
        end else begin
          done  = 1'b1;
          fault = 1'b1;
          st_d  = W_IDLE;
        end
      end
      W_PTE_REQ:  if (mem_req_ready) st_d = W_PTE_WAIT;
      W_PTE_WAIT: if (mem_rsp_valid) begin
        done  = 1'b1;
        fault = !present;
        st_d  = W_IDLE;
      end
      default:    st_d = W_IDLE;
    endcase
  end

  assign mem_req_valid = (st_q == W_DIR_REQ) || (st_q == W_PTE_REQ);
  assign mem_req_addr  = (st_q == W_PTE_REQ)
                       ? {tbl_q, vpn[IDX_W-1:0], 2'b00}
                       : {dir_base, vpn[VPN_W-1:IDX_W], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (tbl_en) tbl_q <= pfn;
  end
endmodule

// File: rtl/pager_mmu.sv
module pager_mmu
  import pager_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_enable,
  input  logic [VPN_W-1:0] dir_base,
  input  logic             tlb_flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  output logic             rsp_valid,
  output logic [LA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [LA_W-1:0]  fault_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [LA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [LA_W-1:0]  mem_rsp_data
);
  logic             rstn_s;
  mmu_st_e          st_q, st_d;
  logic [LA_W-1:0]  la_q, rsp_paddr_q, rsp_paddr_d, fa_q;
  logic             rsp_fault_q, rsp_fault_d;
  logic             la_en, rsp_en, fa_en, walk_start, accept;
  logic             tlb_hit, hit_use, fill_en;
  logic [VPN_W-1:0] hit_pfn, w_pfn;
  logic             w_done, w_fault;

  pager_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_s)
  );

  pager_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(VPN_W), .PFN_W(VPN_W)) i_tlb (
    .clk(clk), .rst_n(rstn_s),
    .lookup_tag(req_laddr[LA_W-1:OFF_W]), .hit(tlb_hit), .hit_pfn(hit_pfn),
    .flush(tlb_flush), .fill_en(fill_en),
    .fill_tag(la_q[LA_W-1:OFF_W]), .fill_pfn(w_pfn)
  );

  pager_walker i_walker (
    .clk(clk), .rst_n(rstn_s), .start(walk_start),
    .vpn(la_q[LA_W-1:OFF_W]), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(w_done), .fault(w_fault), .pfn(w_pfn)
  );

  assign req_ready = (st_q == M_IDLE) && rstn_s;
  assign accept    = req_valid && req_ready;
  assign hit_use   = tlb_hit && !tlb_flush;
  assign fill_en   = (st_q == M_WALK) && w_done && !w_fault;

  always_comb begin
    st_d        = st_q;
    la_en       = 1'b0;
    rsp_en      = 1'b0;
    fa_en       = 1'b0;
    walk_start  = 1'b0;
    rsp_paddr_d = '0;
    rsp_fault_d = 1'b0;
    unique case (st_q)
      M_IDLE: if (accept) begin
        la_en = 1'b1;
        if (!pg_enable) begin
          rsp_en      = 1'b1;
          rsp_paddr_d = req_laddr;
          st_d        = M_RESP;
        end else if (hit_use) begin
          rsp_en      = 1'b1;
          rsp_paddr_d = {hit_pfn, req_laddr[OFF_W-1:0]};
          st_d        = M_RESP;
        end else begin
          walk_start = 1'b1;
          st_d       = M_WALK;
        end
      end
      M_WALK: if (w_done) begin
        rsp_en = 1'b1;
        if (w_fault) begin
          rsp_fault_d = 1'b1;
          fa_en       = 1'b1;
        end else begin
          rsp_paddr_d = {w_pfn, la_q[OFF_W-1:0]};
        end
        st_d = M_RESP;
      end
      M_RESP:  st_d = M_IDLE;
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      st_q        <= M_IDLE;
      rsp_paddr_q <= '0;
      rsp_fault_q <= 1'b0;
      fa_q        <= '0;
    end else begin
      st_q <= st_d;
      if (rsp_en) begin
        rsp_paddr_q <= rsp_paddr_d;
        rsp_fault_q <= rsp_fault_d;
      end
      if (fa_en) fa_q <= la_q;
    end
  end

  always_ff @(posedge clk) begin
    if (la_en) la_q <= req_laddr;
  end

  assign rsp_valid  = (st_q == M_RESP);
  assign rsp_paddr  = rsp_paddr_q;
  assign rsp_fault  = rsp_fault_q;
  assign fault_addr = fa_q;
endmodule

// File: rtl/pager_mmu_chk.sv
module pager_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pg_enable,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_laddr,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [31:0] fault_addr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pg_enable) |=>
      (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr)));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

  assert_fault_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_addr != $past(fault_addr)) |-> (rsp_valid && rsp_fault));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind pager_mmu pager_mmu_chk i_pager_mmu_chk (
  .clk(clk), .rst_n(rst_n), .pg_enable(pg_enable),
  .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .fault_addr(fault_addr), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/test_pager_mmu.sv
`timescale 1ns/1ps
module test_pager_mmu;
  localparam logic [19:0] DIR_BASE = 20'h00010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pg_enable, tlb_flush, flush_tb, flush_mem;
  logic        req_valid, req_ready;
  logic [31:0] req_laddr;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int  total = 0, bad = 0, nreq = 0;
  bit  finished = 0, stall_mode = 0, flush_on_fill = 0, pend = 0;
  logic [31:0] pend_addr;

  always #4 clk = ~clk;
  assign tlb_flush = flush_tb | flush_mem;

  pager_mmu i_pager_mmu (
    .clk(clk), .rst_n(rst_n), .pg_enable(pg_enable), .dir_base(DIR_BASE),
    .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .fault_addr(fault_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // Table image: directory entry 5 absent; table t = 0x100+dir index;
  // page entry 7 absent; frame number = ~linear[31:12].
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] pg = a[31:12];
    logic [9:0]  ix = a[11:2];
    logic [19:0] ti;
    if (pg == DIR_BASE)
      return (ix == 10'd5) ? 32'h0 : {20'h00100 + {10'd0, ix}, 11'd0, 1'b1};
    if (pg >= 20'h00100 && pg < 20'h00500) begin
      ti = pg - 20'h00100;
      return (ix == 10'd7) ? 32'h0 : {~{ti[9:0], ix}, 11'd0, 1'b1};
    end
    return 32'hDEADBEE0;
  endfunction

  function automatic bit in_table(input logic [31:0] a);
    return a[31:12] >= 20'h00100 && a[31:12] < 20'h00500;
  endfunction

  always @(negedge clk) begin
    flush_mem = 1'b0;
    if (!rst_n) begin
      pend = 0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b1;
    end else begin
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
        if (flush_on_fill && in_table(pend_addr)) flush_mem = 1'b1;
        pend = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; pend_addr = mem_req_addr; nreq++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic en, input logic [31:0] la, input logic fl,
                       output logic [31:0] pa, output logic flt, output int lat,
                       output int nr, output logic rdy_busy);
    int n0;
    @(negedge clk);
    n0 = nreq;
    pg_enable = en; req_laddr = la; req_valid = 1'b1; flush_tb = fl;
    @(negedge clk);
    req_valid = 1'b0; flush_tb = 1'b0;
    rdy_busy = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk); lat++;
    end
    pa = rsp_paddr; flt = rsp_fault; nr = nreq - n0;
  endtask

  function automatic logic [31:0] exp_pa(input logic [31:0] la);
    return {~la[31:12], la[11:0]};
  endfunction

  typedef struct packed {
    logic        en;
    logic [2:0]  kind;   // 0 bypass, 1 miss, 2 hit, 3 dir fault, 4 page fault
    logic [31:0] la;
  } vec_t;

  localparam vec_t VTAB [0:8] = '{
    '{1'b0, 3'd0, 32'h12345678},
    '{1'b1, 3'd1, 32'h00400123},
    '{1'b1, 3'd2, 32'h00400FFF},
    '{1'b1, 3'd3, 32'h01407ABC},
    '{1'b1, 3'd4, 32'h00807000},
    '{1'b1, 3'd1, 32'hFFC01234},
    '{1'b1, 3'd2, 32'hFFC01000},
    '{1'b0, 3'd0, 32'h00400123},
    '{1'b1, 3'd2, 32'h00400ABC}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa; logic flt; int lat; int nr; logic rb;
    rst_n = 1'b0; pg_enable = 1'b0; flush_tb = 1'b0; req_valid = 1'b0; req_laddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: reset state
    check(req_ready == 1'b1, "R12 req_ready", {31'd0, req_ready}, 32'd1);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R12 idle outputs",
          {30'd0, rsp_valid, mem_req_valid}, 32'd0);
    check(fault_addr == 32'h0, "R12 fault_addr", fault_addr, 32'h0);

    foreach (VTAB[k]) begin
      xlate(VTAB[k].en, VTAB[k].la, 1'b0, pa, flt, lat, nr, rb);
      case (VTAB[k].kind)
        3'd0: begin
          check(pa == VTAB[k].la && !flt, "R1 bypass addr", pa, VTAB[k].la);
          check(lat == 1 && nr == 0, "R1 bypass latency", lat * 16 + nr, 32'd16);
        end
        3'd1: begin
          check(pa == exp_pa(VTAB[k].la) && !flt, "R2 R3 walk addr", pa, exp_pa(VTAB[k].la));
          check(nr == 2, "R3 two reads", nr, 32'd2);
          check(rb == 1'b0, "R10 busy ready", {31'd0, rb}, 32'd0);
        end
        3'd2: begin
          check(pa == exp_pa(VTAB[k].la) && !flt, "R7 hit addr", pa, exp_pa(VTAB[k].la));
          check(lat == 1 && nr == 0, "R7 hit latency", lat * 16 + nr, 32'd16);
        end
        3'd3: begin
          check(flt && pa == 32'h0, "R4 dir fault", {pa[30:0], flt}, 32'd1);
          check(nr == 1, "R4 one read", nr, 32'd1);
          check(fault_addr == VTAB[k].la, "R6 fault_addr", fault_addr, VTAB[k].la);
        end
        default: begin
          check(flt && pa == 32'h0, "R5 page fault", {pa[30:0], flt}, 32'd1);
          check(nr == 2, "R5 two reads", nr, 32'd2);
          check(fault_addr == VTAB[k].la, "R6 fault_addr", fault_addr, VTAB[k].la);
        end
      endcase
    end
    // R6: unchanged by later good translations
    check(fault_addr == 32'h00807000, "R6 hold", fault_addr, 32'h00807000);
    // R11: single-cycle pulse
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 pulse", {31'd0, rsp_valid}, 32'd0);

    // R9: idle flush
    @(negedge clk); flush_tb = 1'b1; @(negedge clk); flush_tb = 1'b0;
    xlate(1'b1, 32'h00400123, 1'b0, pa, flt, lat, nr, rb);
    check(nr == 2 && pa == exp_pa(32'h00400123), "R9 flush idle", nr, 32'd2);
    // R9: flush together with acceptance
    xlate(1'b1, 32'h00400123, 1'b1, pa, flt, lat, nr, rb);
    check(nr == 2 && pa == exp_pa(32'h00400123), "R9 flush at accept", nr, 32'd2);
    // R9: flush together with fill
    flush_on_fill = 1;
    xlate(1'b1, 32'hFFC01234, 1'b0, pa, flt, lat, nr, rb);
    flush_on_fill = 0;
    check(pa == exp_pa(32'hFFC01234), "R9 fill addr", pa, exp_pa(32'hFFC01234));
    xlate(1'b1, 32'hFFC01234, 1'b0, pa, flt, lat, nr, rb);
    check(nr == 2, "R9 flush beats fill", nr, 32'd2);

    // R8: round-robin over 8 entries
    @(negedge clk); flush_tb = 1'b1; @(negedge clk); flush_tb = 1'b0;
    for (int p = 16; p <= 24; p++) xlate(1'b1, p << 12, 1'b0, pa, flt, lat, nr, rb);
    xlate(1'b1, 32'h00011000, 1'b0, pa, flt, lat, nr, rb);
    check(nr == 0 && pa == exp_pa(32'h00011000), "R8 second page kept", nr, 32'd0);
    xlate(1'b1, 32'h00010000, 1'b0, pa, flt, lat, nr, rb);
    check(nr == 2, "R8 first page evicted", nr, 32'd2);

    // R10: stalled request port
    stall_mode = 1;
    xlate(1'b1, 32'h00405ABC, 1'b0, pa, flt, lat, nr, rb);
    stall_mode = 0;
    check(pa == exp_pa(32'h00405ABC) && nr == 2, "R10 stall", pa, exp_pa(32'h00405ABC));

    // R12: reset empties the cache and clears fault_addr
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fault_addr == 32'h0 && req_ready, "R12 after reset", fault_addr, 32'h0);
    xlate(1'b1, 32'h00405ABC, 1'b0, pa, flt, lat, nr, rb);
    check(nr == 2, "R12 cache empty", nr, 32'd2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule